// File: doc/BRIEF.md
# Microprogram Sequencer with OR-Dispatch

This block decides which control-store word a microprogrammed control unit reads next. It holds a microprogram counter. Each microinstruction carries a two-bit sequencing code and a base address. The code tells the block to step to the following word, to jump to the base address, to return to the fetch microroutine, or to dispatch on the machine instruction.

A dispatch forms its target by bitwise-ORing three instruction-register bits into the base address. The opcode bits are IR6, IR5 and IR4. When the base has zeros in those positions, the OR acts as a concatenation. One microinstruction can then fan out to up to eight successors, each picked by the opcode, with no adder and no lookup table.

The counter is loaded on every clock edge, so the next control-store address comes straight from a register. The control part decodes the sequencing code into a small set of select strobes. The datapath part builds the address and holds the counter.

Top module: `useq_top`

## Requirements
- R1: While `rstN` is low, `nextAddr` is 0 and stays at 0.
- R2: With `seqOp` = 2'b00 (step), the next clock edge sets `nextAddr` to its previous value plus one, modulo 256 (0xFF steps to 0x00).
- R3: With `seqOp` = 2'b01 (jump), the next clock edge sets `nextAddr` to `baseAddr`.
- R4: With `seqOp` = 2'b10 (dispatch), the next clock edge sets `nextAddr` to `baseAddr | (irField << OR_LSB)`, where `OR_LSB` defaults to 0. In `irField`, bit 2 carries IR6, bit 1 carries IR5 and bit 0 carries IR4. Base bits that are already set stay set: the result is an OR, not a sum.
- R5: With `seqOp` = 2'b11 (end), the next clock edge sets `nextAddr` to 0, the fetch microroutine.
- R6: When a dispatch base has zeros in the three OR positions, the low three bits of the result equal `irField` and the upper bits equal the base. A single dispatch word therefore reaches a distinct successor for each opcode value.
- R7: `irField` is sampled at the same edge that consumes the dispatch microinstruction. For the step, jump and end codes it has no effect on `nextAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| seqOp | input | 2 | Sequencing code of the current microinstruction |
| baseAddr | input | 8 | Base/target address field of the current microinstruction |
| irField | input | 3 | Instruction-register bits IR6..IR4 |
| nextAddr | output | 8 | Registered control-store address (microprogram counter) |

## Verification
The bench runs small microprograms from a control-store model. In them, one dispatch word must reach a different end routine for each opcode value. A design that ignored the opcode bits, or that shifted them into the wrong positions, would land every opcode on the same word.

A dispatch whose base already has low bits set tells an OR apart from an add: 0x05 with opcode 3 must give 0x07, not 0x08. Stepping from 0xFF must wrap to 0x00. Random sequencing codes, bases and opcodes are also applied, and the opcode changes on every step. This catches a design that lets the opcode leak into step, jump or end targets, or one that samples the opcode a cycle late.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    SEQ_STEP     = 2'b00,
    SEQ_JUMP     = 2'b01,
    SEQ_DISPATCH = 2'b10,
    SEQ_END      = 2'b11
  } seqOp_e;

  // Strobes from the control decode to the address datapath
  typedef struct packed {
    logic selInc;   // take counter + 1
    logic selBase;  // take the base address
    logic orIr;     // merge opcode bits into the base
  } seqStrobe_t;
endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] seqOp,
  output seqStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    unique case (seqOp_e'(seqOp))
      SEQ_STEP:     strobe.selInc  = 1'b1;
      SEQ_JUMP:     strobe.selBase = 1'b1;
      SEQ_DISPATCH: begin
        strobe.selBase = 1'b1;
        strobe.orIr    = 1'b1;
      end
      default:      strobe = '0; // end: back to fetch
    endcase
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.selInc && strobe.selBase)) else $error("strobe clash"); // R2
  AST_OR_NEEDS_BASE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.orIr |-> strobe.selBase) else $error("orIr without base"); // R4
endmodule

// File: rtl/useq_path.sv
module useq_path
  import useq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IR_W   = 3,
  parameter int OR_LSB = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [IR_W-1:0]   irField,
  output logic [ADDR_W-1:0] upc
);
  localparam logic [ADDR_W-1:0] FETCH_ADDR = '0;
  localparam int OR_MSB = OR_LSB + IR_W - 1;

  logic [ADDR_W-1:0] irWide;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] upcNext;

  assign irWide = ADDR_W'(irField) << OR_LSB;
  assign target = strobe.orIr ? (baseAddr | irWide) : baseAddr;

  always_comb begin
    if (strobe.selInc)       upcNext = upc + ADDR_W'(1);
    else if (strobe.selBase) upcNext = target;
    else                     upcNext = FETCH_ADDR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upc <= FETCH_ADDR;
    else       upc <= upcNext;
  end

  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.selInc)) |-> upc == $past(upc) + ADDR_W'(1))
    else $error("step"); // R2
  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.selBase) && !$past(strobe.orIr)) |-> upc == $past(baseAddr))
    else $error("jump"); // R3
  AST_DISPATCH_OR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.orIr)) |-> (upc & ~$past(irWide)) == ($past(baseAddr) & ~$past(irWide)))
    else $error("dispatch"); // R4
  AST_DISPATCH_CAT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.orIr) && $past(baseAddr[OR_MSB:OR_LSB]) == '0)
      |-> upc[OR_MSB:OR_LSB] == $past(irField))
    else $error("concat"); // R6
  AST_END_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobe.selInc) && !$past(strobe.selBase)) |-> upc == FETCH_ADDR)
    else $error("end"); // R5
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IR_W   = 3,
  parameter int OR_LSB = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        seqOp,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [IR_W-1:0]   irField,
  output logic [ADDR_W-1:0] nextAddr
);
  seqStrobe_t strobe;

  useq_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .seqOp  (seqOp),
    .strobe (strobe)
  );

  useq_path #(.ADDR_W(ADDR_W), .IR_W(IR_W), .OR_LSB(OR_LSB)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .baseAddr (baseAddr),
    .irField  (irField),
    .upc      (nextAddr)
  );
endmodule

// File: tb/sim_useq_top.sv
module sim_useq_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] seqOp = 2'b00;
  logic [7:0] baseAddr = 8'h00;
  logic [2:0] irField = 3'b000;
  logic [7:0] nextAddr;

  int checks = 0;
  int fails  = 0;
  logic [7:0] expAddr = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_top u0 (
    .clk      (clk),
    .rstN     (rstN),
    .seqOp    (seqOp),
    .baseAddr (baseAddr),
    .irField  (irField),
    .nextAddr (nextAddr)
  );

  // Expected next address from the requirements
  function automatic logic [7:0] calcNext(logic [1:0] op, logic [7:0] base,
                                          logic [2:0] ir, logic [7:0] cur);
    case (op)
      2'b00:   return cur + 8'd1;          // R2
      2'b01:   return base;                // R3
      2'b10:   return base | {5'b0, ir};   // R4
      default: return 8'h00;               // R5
    endcase
  endfunction

  // Control-store model: 0 step, 1 dispatch on 0x20, 0x20..0x27 end
  function automatic logic [9:0] romWord(logic [7:0] a);
    if (a == 8'h00)      return {2'b00, 8'h00};
    else if (a == 8'h01) return {2'b10, 8'h20};
    else                 return {2'b11, 8'h00};
  endfunction

  task automatic check(string req, logic [7:0] exp);
    checks++;
    if (nextAddr !== exp) begin
      fails++;
      $display("FAIL %s: nextAddr=%02h expected=%02h", req, nextAddr, exp);
    end
  endtask

  // Called at a negedge: apply inputs, wait one edge, check at next negedge
  task automatic step(string req, logic [1:0] op, logic [7:0] base, logic [2:0] ir);
    seqOp = op; baseAddr = base; irField = ir;
    expAddr = calcNext(op, base, ir, expAddr);
    @(posedge clk);
    @(negedge clk);
    check(req, expAddr);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset holds zero even with active inputs
    seqOp = 2'b01; baseAddr = 8'hA5;
    repeat (3) @(negedge clk);
    check("R1", 8'h00);
    @(negedge clk);
    seqOp = 2'b00; baseAddr = 8'h00;
    rstN = 1'b1;
    expAddr = 8'h00;

    // R6: dispatch fan-out through the control-store model
    for (int k = 0; k < 8; k++) begin
      logic [9:0] w;
      for (int s = 0; s < 3; s++) begin
        w = romWord(expAddr);
        step((s == 1) ? "R6" : "R4", w[9:8], w[7:0], 3'(k));
      end
      if (nextAddr !== 8'h00) begin
        checks++; fails++;
        $display("FAIL R5: nextAddr=%02h expected=00", nextAddr);
      end
    end

    // R4: OR not add
    step("R4", 2'b10, 8'h05, 3'd3);
    if (expAddr !== 8'h07) $display("FAIL R4: model=%02h expected=07", expAddr);
    // R2: wrap
    step("R3", 2'b01, 8'hFF, 3'd7);
    step("R2", 2'b00, 8'h12, 3'd5);
    // R7: ir ignored on jump/step/end
    step("R7", 2'b01, 8'h40, 3'd7);
    step("R7", 2'b00, 8'h00, 3'd7);
    step("R5", 2'b11, 8'hFF, 3'd7);
    // R7: ir sampled at the dispatch edge, changing right after
    step("R7", 2'b10, 8'h80, 3'd2);
    step("R7", 2'b00, 8'h00, 3'd5);

    // Random mix, R2 R3 R4 R5 R7
    for (int n = 0; n < 2000; n++) begin
      step("R2-R5 random", 2'($urandom), 8'($urandom), 3'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule